// File: doc/BRIEF.md
# Floating-Point Compare into Condition Field

This block compares two floating-point operands under one of three relations (greater-than, less-than, equal) and folds the outcome into a 4-bit field of a 32-bit condition register. It handles scalar single precision (low 32 bits of each 64-bit operand), scalar double precision (all 64 bits), and a paired-single form in which the upper and lower 32-bit halves are compared as two independent lanes.

The caller presents both operands, an 11-bit function code, a precision select, a 3-bit field index and the current condition register, and raises `in_valid` for one cycle. One cycle later `done` pulses, `cr_out` holds the condition register with only the chosen field rewritten, and `invalid_out` reports whether a signaling NaN took part in an unordered comparison. Operands that involve any NaN never satisfy a relation.

Top module: `fpcmp_crf`

## Requirements
- R1: After reset `cr_out` is 0, `done` is 0 and `invalid_out` is 0; a cycle with `in_valid` high makes `done` high for exactly the following cycle, with `cr_out` and `invalid_out` valid in that cycle, and `invalid_out` is 0 in every cycle where `done` is 0.
- R2: The low four bits of `func_code` pick the relation (0xC greater-than, 0xD less-than, 0xE equal); the upper seven bits must be 0x2C with `prec_sel`=0 (single), 0x2E with `prec_sel`=1 (double) or 0x28 with `prec_sel`=2 (paired).
- R3: A scalar compare writes 0b0100 into the selected field when the relation holds and 0b0000 when it does not.
- R4: Field index k occupies `cr_out` bits (7-k)*4+3 down to (7-k)*4, so index 0 is the most significant nibble; all other nibbles equal `cr_in`.
- R5: A paired compare evaluates the upper 32-bit lane to hit bit h and the lower lane to hit bit l, and writes the nibble {h, l, h|l, h&l} (most significant bit first).
- R6: A scalar single compare depends only on bits 31:0 of each operand; bits 63:32 have no effect.
- R7: When either operand of a lane is a NaN (all-ones exponent, nonzero fraction) the lane is unordered and every relation is false for it.
- R8: `invalid_out` is 1 only when some evaluated lane is unordered and one of its operands is a signaling NaN (NaN whose most significant fraction bit is 0); in paired mode either lane can raise it.
- R9: +0 and -0 compare equal; infinities are ordered values, so -inf < finite < +inf, and negative values order by reversed magnitude.
- R10: A function code and precision select that do not form a legal pair under R2 (including `prec_sel`=3) leave `cr_out` equal to `cr_in` with `invalid_out` 0, while `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per compare |
| func_code | input | 11 | Function code: group in bits 10:4, relation in bits 3:0 |
| prec_sel | input | 2 | 0 single, 1 double, 2 paired single, 3 reserved |
| dest_field | input | 3 | Index of the condition field to rewrite |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cr_in | input | 32 | Current condition register |
| cr_out | output | 32 | Updated condition register |
| invalid_out | output | 1 | Signaling NaN seen in an unordered compare |
| done | output | 1 | Result valid pulse |

## Verification
The directed tests aim at the sign-and-magnitude ordering corners: signed zeros, infinities and pairs of negative numbers, where a design comparing raw bit patterns as integers would call -0 less than +0 or rank -2 above -1. Quiet and signaling NaNs are sent in every precision and in either paired lane, which exposes a design that lets NaN bit patterns satisfy equality or that raises the invalid flag for quiet NaNs or ignores one lane. Field placement is checked at both end indices against patterned `cr_in` values, catching a reversed index or a clobbered neighbour, and mismatched code and precision pairs show whether a design wrongly updates the register on an illegal request. Scalar single compares with different upper halves reveal any leak of the unused bits.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int CODE_W     = 11;
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int CR_W       = FIELD_W * NUM_FIELDS;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int WORD_W     = 64;
    localparam int NUM_LANES  = 2;
    localparam int LANE_W     = WORD_W / NUM_LANES;
    localparam int SGL_EXP    = 8;
    localparam int SGL_FRAC   = 23;
    localparam int DBL_EXP    = 11;
    localparam int DBL_FRAC   = 52;
    localparam int GRP_W      = CODE_W - 4;

    localparam logic [GRP_W-1:0] GRP_SGL  = 7'h2C;
    localparam logic [GRP_W-1:0] GRP_DBL  = 7'h2E;
    localparam logic [GRP_W-1:0] GRP_PAIR = 7'h28;

    typedef enum logic [1:0] {
        PREC_SGL  = 2'd0,
        PREC_DBL  = 2'd1,
        PREC_PAIR = 2'd2,
        PREC_RSV  = 2'd3
    } prec_e;

    typedef enum logic [1:0] {
        REL_NONE = 2'd0,
        REL_GT   = 2'd1,
        REL_LT   = 2'd2,
        REL_EQ   = 2'd3
    } rel_e;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
        logic unord;
        logic snan;
    } lane_res_t;

    typedef struct packed {
        logic  legal;
        prec_e prec;
        rel_e  rel;
    } dec_t;

    function automatic logic lane_hit(lane_res_t r, rel_e rel);
        logic h;
        case (rel)
            REL_GT:  h = r.gt;
            REL_LT:  h = r.lt;
            REL_EQ:  h = r.eq;
            default: h = 1'b0;
        endcase
        return h;
    endfunction

    function automatic logic lane_invalid(lane_res_t r);
        return r.unord & r.snan;
    endfunction

endpackage

// File: rtl/fpcmp_decode.sv
module fpcmp_decode
    import fpcmp_pkg::*;
(
    input  logic [CODE_W-1:0] func_code,
    input  logic [1:0]        prec_sel,
    output dec_t              dec
);
    logic [GRP_W-1:0] grp;
    logic [GRP_W-1:0] want_grp;
    logic             grp_ok;
    rel_e             rel;
    prec_e            prec;

    assign grp  = func_code[CODE_W-1:4];
    assign prec = prec_e'(prec_sel);

    always_comb begin
        case (func_code[3:0])
            4'hC:    rel = REL_GT;
            4'hD:    rel = REL_LT;
            4'hE:    rel = REL_EQ;
            default: rel = REL_NONE;
        endcase
    end

    always_comb begin
        grp_ok   = 1'b1;
        want_grp = GRP_SGL;
        case (prec)
            PREC_SGL:  want_grp = GRP_SGL;
            PREC_DBL:  want_grp = GRP_DBL;
            PREC_PAIR: want_grp = GRP_PAIR;
            default:   grp_ok   = 1'b0;
        endcase
    end

    assign dec.legal = grp_ok && (grp == want_grp) && (rel != REL_NONE);
    assign dec.prec  = prec;
    assign dec.rel   = rel;

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output lane_res_t             res
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic              a_sign, b_sign;
    logic [EXP_W-1:0]  a_exp, b_exp;
    logic [FRAC_W-1:0] a_frac, b_frac;
    logic [W-2:0]      a_mag, b_mag;
    logic              a_nan, b_nan, a_snan, b_snan;
    logic              both_zero, unord;
    logic              raw_eq, raw_lt;

    assign a_sign = a[W-1];
    assign b_sign = b[W-1];
    assign a_exp  = a[W-2:FRAC_W];
    assign b_exp  = b[W-2:FRAC_W];
    assign a_frac = a[FRAC_W-1:0];
    assign b_frac = b[FRAC_W-1:0];
    assign a_mag  = a[W-2:0];
    assign b_mag  = b[W-2:0];

    assign a_nan  = (&a_exp) && (|a_frac);
    assign b_nan  = (&b_exp) && (|b_frac);
    assign a_snan = a_nan && !a_frac[FRAC_W-1];
    assign b_snan = b_nan && !b_frac[FRAC_W-1];
    assign unord  = a_nan || b_nan;

    assign both_zero = (a_mag == '0) && (b_mag == '0);
    assign raw_eq    = both_zero || (a == b);

    always_comb begin
        if (both_zero)
            raw_lt = 1'b0;
        else if (a_sign != b_sign)
            raw_lt = a_sign;
        else if (!a_sign)
            raw_lt = a_mag < b_mag;
        else
            raw_lt = a_mag > b_mag;
    end

    assign res.eq    = raw_eq && !unord;
    assign res.lt    = raw_lt && !unord;
    assign res.gt    = !raw_eq && !raw_lt && !unord;
    assign res.unord = unord;
    assign res.snan  = a_snan || b_snan;

endmodule

// File: rtl/fpcmp_field_ins.sv
module fpcmp_field_ins
    import fpcmp_pkg::*;
(
    input  logic [CR_W-1:0]    cr_in,
    input  logic [IDX_W-1:0]   idx,
    input  logic [FIELD_W-1:0] nib,
    input  logic               wr_en,
    output logic [CR_W-1:0]    cr_out
);
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int POS = (NUM_FIELDS - 1 - f) * FIELD_W;
        assign cr_out[POS +: FIELD_W] =
            (wr_en && (idx == IDX_W'(f))) ? nib : cr_in[POS +: FIELD_W];
    end

endmodule

// File: rtl/fpcmp_crf.sv
module fpcmp_crf
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [10:0]       func_code,
    input  logic [1:0]        prec_sel,
    input  logic [2:0]        dest_field,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [31:0]       cr_in,
    output logic [31:0]       cr_out,
    output logic              invalid_out,
    output logic              done
);
    dec_t                dec;
    lane_res_t           res_d;
    lane_res_t           res_s [NUM_LANES];
    logic                hit_d, hit_lo, hit_hi;
    logic [FIELD_W-1:0]  nib;
    logic                inv_raw;
    logic [CR_W-1:0]     cr_next;
    logic [CR_W-1:0]     cr_q;
    logic                inv_q, done_q;

    fpcmp_decode u_dec (
        .func_code (func_code),
        .prec_sel  (prec_sel),
        .dec       (dec)
    );

    fpcmp_lane #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_dbl (
        .a   (op_a),
        .b   (op_b),
        .res (res_d)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_sgl
        fpcmp_lane #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_sgl (
            .a   (op_a[ln*LANE_W +: LANE_W]),
            .b   (op_b[ln*LANE_W +: LANE_W]),
            .res (res_s[ln])
        );
    end

    assign hit_d  = lane_hit(res_d, dec.rel);
    assign hit_lo = lane_hit(res_s[0], dec.rel);
    assign hit_hi = lane_hit(res_s[1], dec.rel);

    always_comb begin
        nib     = '0;
        inv_raw = 1'b0;
        case (dec.prec)
            PREC_SGL: begin
                nib     = {1'b0, hit_lo, 2'b00};
                inv_raw = lane_invalid(res_s[0]);
            end
            PREC_DBL: begin
                nib     = {1'b0, hit_d, 2'b00};
                inv_raw = lane_invalid(res_d);
            end
            PREC_PAIR: begin
                nib     = {hit_hi, hit_lo, hit_hi | hit_lo, hit_hi & hit_lo};
                inv_raw = lane_invalid(res_s[0]) | lane_invalid(res_s[1]);
            end
            default: begin
                nib     = '0;
                inv_raw = 1'b0;
            end
        endcase
    end

    fpcmp_field_ins u_ins (
        .cr_in  (cr_in),
        .idx    (dest_field),
        .nib    (nib),
        .wr_en  (dec.legal),
        .cr_out (cr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q   <= '0;
            inv_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= in_valid;
            inv_q  <= in_valid && dec.legal && inv_raw;
            if (in_valid)
                cr_q <= cr_next;
        end
    end

    assign cr_out      = cr_q;
    assign invalid_out = inv_q;
    assign done        = done_q;

endmodule

// File: rtl/fpcmp_crf_chk.sv
module fpcmp_crf_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  prec_sel,
    input logic [2:0]  dest_field,
    input logic [31:0] cr_in,
    input logic [31:0] cr_out,
    input logic        invalid_out,
    input logic        done
);
    function automatic logic [31:0] keep_mask(logic [2:0] idx);
        return ~(32'hF << ((3'd7 - idx) * 4));
    endfunction

    function automatic logic [3:0] field_of(logic [31:0] cr, logic [2:0] idx);
        return cr[(3'd7 - idx) * 4 +: 4];
    endfunction

    // R1
    a_r1_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);

    a_r1_no_done_without_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);

    a_r1_invalid_with_done: assert property (@(posedge clk) disable iff (rst)
        invalid_out |-> done);

    // R4
    a_r4_other_fields_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> ((cr_out & keep_mask($past(dest_field)))
                  == ($past(cr_in) & keep_mask($past(dest_field)))));

    // R3
    a_r3_scalar_nibble_form: assert property (@(posedge clk) disable iff (rst)
        (done && $past(prec_sel) != 2'd2) |->
            (field_of(cr_out, $past(dest_field)) == 4'h0 ||
             field_of(cr_out, $past(dest_field)) == 4'h4 ||
             field_of(cr_out, $past(dest_field)) == field_of($past(cr_in), $past(dest_field))));

    // R5
    a_r5_paired_nibble_form: assert property (@(posedge clk) disable iff (rst)
        (done && $past(prec_sel) == 2'd2) |->
            ((field_of(cr_out, $past(dest_field)) ==
              field_of($past(cr_in), $past(dest_field))) ||
             ((field_of(cr_out, $past(dest_field))[1] ==
               (field_of(cr_out, $past(dest_field))[3] | field_of(cr_out, $past(dest_field))[2])) &&
              (field_of(cr_out, $past(dest_field))[0] ==
               (field_of(cr_out, $past(dest_field))[3] & field_of(cr_out, $past(dest_field))[2])))));

endmodule

bind fpcmp_crf fpcmp_crf_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .prec_sel    (prec_sel),
    .dest_field  (dest_field),
    .cr_in       (cr_in),
    .cr_out      (cr_out),
    .invalid_out (invalid_out),
    .done        (done)
);

// File: tb/sim_fpcmp_crf.sv
`timescale 1ns/1ps
module sim_fpcmp_crf;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [10:0] func_code;
    logic [1:0]  prec_sel;
    logic [2:0]  dest_field;
    logic [63:0] op_a, op_b;
    logic [31:0] cr_in;
    logic [31:0] cr_out;
    logic        invalid_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] S_ONE  = 32'h3F800000;
    localparam logic [31:0] S_TWO  = 32'h40000000;
    localparam logic [31:0] S_MONE = 32'hBF800000;
    localparam logic [31:0] S_MTWO = 32'hC0000000;
    localparam logic [31:0] S_PINF = 32'h7F800000;
    localparam logic [31:0] S_MINF = 32'hFF800000;
    localparam logic [31:0] S_MZ   = 32'h80000000;
    localparam logic [31:0] S_QNAN = 32'h7FC00000;
    localparam logic [31:0] S_SNAN = 32'h7F800001;
    localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] D_ONEP = 64'h3FF0000000000001;
    localparam logic [63:0] D_TWO  = 64'h4000000000000000;
    localparam logic [63:0] D_MTWO = 64'hC000000000000000;
    localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;

    always #2.5 clk = ~clk;

    fpcmp_crf u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(func_code),
        .prec_sel(prec_sel), .dest_field(dest_field), .op_a(op_a), .op_b(op_b),
        .cr_in(cr_in), .cr_out(cr_out), .invalid_out(invalid_out), .done(done)
    );

    function automatic logic [31:0] put(logic [31:0] cr, int idx, logic [3:0] nib);
        logic [31:0] r = cr;
        r[(7 - idx) * 4 +: 4] = nib;
        return r;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check the result one cycle later.
    task automatic run_cmp(string req, logic [10:0] code, logic [1:0] prec, int idx,
                           logic [63:0] a, logic [63:0] b, logic [31:0] cr,
                           logic [31:0] exp_cr, logic exp_inv);
        @(negedge clk);
        in_valid = 1'b1; func_code = code; prec_sel = prec;
        dest_field = 3'(idx); op_a = a; op_b = b; cr_in = cr;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "done", {63'd0, done}, 64'd1);
        chk(req, "cr_out", {32'd0, cr_out}, {32'd0, exp_cr});
        chk(req, "invalid", {63'd0, invalid_out}, {63'd0, exp_inv});
    endtask

    task automatic t_reset();
        chk("R1", "reset cr_out", {32'd0, cr_out}, 64'd0);
        chk("R1", "reset done", {63'd0, done}, 64'd0);
        chk("R1", "reset invalid", {63'd0, invalid_out}, 64'd0);
    endtask

    task automatic t_pulse();
        // R1: sNaN request then idle cycle: done and invalid drop
        run_cmp("R1", 11'h2CE, 2'd0, 2, 64'h0, {32'd0, S_SNAN}, 32'h0, 32'h0, 1'b1);
        @(negedge clk);
        chk("R1", "done drops", {63'd0, done}, 64'd0);
        chk("R1", "invalid drops", {63'd0, invalid_out}, 64'd0);
    endtask

    task automatic t_single();
        // R3 R4 R2: field 0 is the top nibble
        run_cmp("R3", 11'h2CC, 2'd0, 0, {32'd0, S_TWO}, {32'd0, S_ONE},
                32'hFFFFFFFF, 32'h4FFFFFFF, 1'b0);
        run_cmp("R4", 11'h2CD, 2'd0, 7, {32'd0, S_TWO}, {32'd0, S_ONE},
                32'h12345678, 32'h12345670, 1'b0);
        run_cmp("R2", 11'h2CD, 2'd0, 4, {32'd0, S_ONE}, {32'd0, S_TWO},
                32'h0, put(32'h0, 4, 4'h4), 1'b0);
    endtask

    task automatic t_upper_ignored();
        // R6: differing upper halves do not affect a single compare
        run_cmp("R6", 11'h2CE, 2'd0, 3, {32'hDEADBEEF, S_ONE}, {32'h00000001, S_ONE},
                32'hAAAAAAAA, put(32'hAAAAAAAA, 3, 4'h4), 1'b0);
        run_cmp("R6", 11'h2CC, 2'd0, 1, {S_MTWO, S_ONE}, {S_PINF, S_TWO},
                32'h0, 32'h0, 1'b0);
    endtask

    task automatic t_ordering();
        run_cmp("R9", 11'h2CE, 2'd0, 2, {32'd0, 32'h0}, {32'd0, S_MZ},
                32'h0, put(32'h0, 2, 4'h4), 1'b0);
        run_cmp("R9", 11'h2CD, 2'd0, 2, {32'd0, S_MZ}, {32'd0, 32'h0},
                32'h0, 32'h0, 1'b0);
        run_cmp("R9", 11'h2CD, 2'd0, 5, {32'd0, S_MINF}, {32'd0, S_PINF},
                32'h0, put(32'h0, 5, 4'h4), 1'b0);
        run_cmp("R9", 11'h2CD, 2'd0, 6, {32'd0, S_MTWO}, {32'd0, S_MONE},
                32'h0, put(32'h0, 6, 4'h4), 1'b0);
        run_cmp("R9", 11'h2CC, 2'd0, 6, {32'd0, S_PINF}, {32'd0, S_TWO},
                32'h0, put(32'h0, 6, 4'h4), 1'b0);
    endtask

    task automatic t_double();
        run_cmp("R3", 11'h2EC, 2'd1, 5, D_TWO, D_ONE, 32'h0, put(32'h0, 5, 4'h4), 1'b0);
        run_cmp("R9", 11'h2ED, 2'd1, 1, D_MTWO, D_ONE, 32'h0, put(32'h0, 1, 4'h4), 1'b0);
        run_cmp("R2", 11'h2EC, 2'd1, 0, D_ONEP, D_ONE, 32'h0, 32'h40000000, 1'b0);
        run_cmp("R2", 11'h2EE, 2'd1, 0, D_ONEP, D_ONE, 32'hF0000000, 32'h0, 1'b0);
    endtask

    task automatic t_nan();
        run_cmp("R7", 11'h2CC, 2'd0, 2, {32'd0, S_QNAN}, {32'd0, S_ONE}, 32'h0, 32'h0, 1'b0);
        run_cmp("R7", 11'h2CE, 2'd0, 2, {32'd0, S_QNAN}, {32'd0, S_QNAN},
                32'h00F00000, 32'h0, 1'b0);
        run_cmp("R8", 11'h2CE, 2'd0, 2, {32'd0, S_ONE}, {32'd0, S_SNAN}, 32'h0, 32'h0, 1'b1);
        run_cmp("R8", 11'h2ED, 2'd1, 4, D_SNAN, D_ONE, 32'h0, 32'h0, 1'b1);
        run_cmp("R7", 11'h2EE, 2'd1, 4, D_QNAN, D_QNAN, 32'h0, 32'h0, 1'b0);
        // R8: NaN in the ignored upper half of a single compare raises nothing
        run_cmp("R8", 11'h2CC, 2'd0, 4, {S_SNAN, S_TWO}, {S_SNAN, S_ONE},
                32'h0, put(32'h0, 4, 4'h4), 1'b0);
    endtask

    task automatic t_paired();
        run_cmp("R5", 11'h28C, 2'd2, 1, {S_TWO, S_ONE}, {S_ONE, S_TWO},
                32'h0, put(32'h0, 1, 4'hA), 1'b0);
        run_cmp("R5", 11'h28D, 2'd2, 1, {S_TWO, S_ONE}, {S_ONE, S_TWO},
                32'h0, put(32'h0, 1, 4'h6), 1'b0);
        run_cmp("R5", 11'h28E, 2'd2, 7, {S_ONE, S_ONE}, {S_ONE, S_ONE},
                32'h0, 32'h0000000F, 1'b0);
        run_cmp("R5", 11'h28C, 2'd2, 3, {S_ONE, S_ONE}, {S_TWO, S_TWO},
                32'hFFFFFFFF, put(32'hFFFFFFFF, 3, 4'h0), 1'b0);
        run_cmp("R8", 11'h28C, 2'd2, 2, {S_SNAN, S_TWO}, {S_ONE, S_ONE},
                32'h0, put(32'h0, 2, 4'h6), 1'b1);
        run_cmp("R8", 11'h28C, 2'd2, 2, {S_TWO, S_QNAN}, {S_ONE, S_ONE},
                32'h0, put(32'h0, 2, 4'hA), 1'b0);
    endtask

    task automatic t_illegal();
        run_cmp("R10", 11'h2CC, 2'd1, 0, {32'd0, S_TWO}, {32'd0, S_ONE},
                32'h13579BDF, 32'h13579BDF, 1'b0);
        run_cmp("R10", 11'h2CE, 2'd3, 0, {32'd0, S_SNAN}, {32'd0, S_ONE},
                32'h2468ACE0, 32'h2468ACE0, 1'b0);
        run_cmp("R10", 11'h2CF, 2'd0, 0, {32'd0, S_ONE}, {32'd0, S_ONE},
                32'h0F0F0F0F, 32'h0F0F0F0F, 1'b0);
        run_cmp("R10", 11'h28E, 2'd0, 5, {S_ONE, S_ONE}, {S_ONE, S_ONE},
                32'h0, 32'h0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; func_code = '0; prec_sel = '0;
        dest_field = '0; op_a = '0; op_b = '0; cr_in = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_pulse();
        t_single();
        t_upper_ignored();
        t_ordering();
        t_double();
        t_nan();
        t_paired();
        t_illegal();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule